// File: doc/BRIEF.md
# Two-Level LED PWM Intensity Generator

This block turns intensity settings into pulse-width-modulated, active-low drive for a bank of LED outputs (17 by default). A single period counter, advanced by an externally supplied tick, is shared by every output. Each output can be driven in one of two ways:

- In split mode, a 4-bit master level sets a window that all outputs share, and each output's own 4-bit level scales its on-time inside that window.
- In global mode, one 8-bit value sets the on-time of every output directly.

Each output has its own PWM enable. When the enable is clear, the output carries a static pin level instead, and the period counter has no effect on it. When no output uses PWM, the block tells the oscillator to stop and holds its counter at zero. New duty values take effect only at the start of a period, so a change of setting never produces a shortened or stretched pulse.

Top module: `pwm2l_top`

## Requirements
- R1: While reset is asserted (rst_n low) and immediately after it, every bit of pin_n is 1 (released) and osc_run is 0.
- R2: The PWM period is 240 ticks. The counter advances by one only on cycles where osc_tick is 1, and it wraps from 239 to 0.
- R3: In split mode (glob_mode = 0), a PWM-enabled output is driven low for M×(I+1) ticks of each period, starting at tick 0. M is master_lvl and I is the output's field indiv_lvl[4i+3:4i]. With M = 0 the output stays released.
- R4: In split mode with M = 15 and I = 15, a PWM-enabled output is low for all 240 ticks. With M = 15 and I = 0 it is low for 15 ticks.
- R5: In global mode (glob_mode = 1), every PWM-enabled output is low for min(G, 240) ticks per period, where G is glob_lvl. The individual levels and the master level have no effect in this mode.
- R6: When pwm_en[i] is 0, pin_n[i] equals static_lvl[i] one clock later (1 = released, 0 = driven low), whatever the counter state.
- R7: Changing any intensity input or the mode in the middle of a period leaves the current period's on-time unchanged. The new on-time applies from the next period.
- R8: osc_run equals the OR of pwm_en one clock later. While osc_run is 0, the period counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the PWM oscillator; each pulse is one tick |
| osc_run | output | 1 | Request for the oscillator to run; low when no output uses PWM |
| glob_mode | input | 1 | 0 = split master/individual mode, 1 = single global setting |
| master_lvl | input | 4 | Master window level, 0 (off) to 15 (full) |
| glob_lvl | input | 8 | Global on-time in ticks, clamped to 240 |
| indiv_lvl | input | 68 | Per-output 4-bit levels; output i uses bits [4i+3:4i] |
| pwm_en | input | 17 | Per-output PWM enable |
| static_lvl | input | 17 | Pin level used when an output's PWM is disabled |
| pin_n | output | 17 | Active-low drive; 0 = LED on |

## Verification
The checker watches four rules on every clock:
- the counter never leaves 0 to 239;
- the counter stays put on cycles without a tick, and reads zero after osc_run is low;
- no stored duty value changes except at a period boundary or while stopped;
- a disabled output always shows last cycle's static level.

Some behaviour only shows up in the bench's scenarios, which count the low cycles in a full period and time the gap between falling edges:
- the arithmetic of the on-time itself, meaning the product in split mode and the clamp in global mode;
- the 240-tick period under different tick rates;
- the rule that a setting changed mid-period takes effect only in the following period.

// File: rtl/pwm2l_pkg.sv
package pwm2l_pkg;

    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_GLOBAL = 1'b1
    } pwm_mode_e;

    // Ticks in one period: full master window times the number of individual steps.
    function automatic int unsigned period_ticks(input int unsigned lvl_w);
        return ((32'd1 << lvl_w) - 32'd1) * (32'd1 << lvl_w);
    endfunction

endpackage

// File: rtl/pwm2l_period_cnt.sv
module pwm2l_period_cnt #(
    parameter int unsigned PERIOD = 240,
    parameter int unsigned VAL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             any_en_i,
    output logic             run_o,
    output logic [VAL_W-1:0] cnt_o,
    output logic             load_o
);
    localparam logic [VAL_W-1:0] LAST = VAL_W'(PERIOD - 1);

    typedef struct packed {
        logic             run;
        logic [VAL_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        st_d     = st_q;
        at_last  = (st_q.cnt == LAST);
        st_d.run = any_en_i;
        if (!st_q.run) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + VAL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Duty values are reloaded while stopped and at every wrap.
    assign load_o = !st_q.run || (tick_i && at_last);
    assign run_o  = st_q.run;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/pwm2l_duty_calc.sv
module pwm2l_duty_calc
    import pwm2l_pkg::*;
#(
    parameter int unsigned N_OUT  = 17,
    parameter int unsigned LVL_W  = 4,
    parameter int unsigned GLB_W  = 8,
    parameter int unsigned VAL_W  = 8,
    parameter int unsigned PERIOD = 240
) (
    input  logic                   glob_mode_i,
    input  logic [LVL_W-1:0]       master_i,
    input  logic [GLB_W-1:0]       glob_i,
    input  logic [N_OUT*LVL_W-1:0] indiv_i,
    output logic [N_OUT*VAL_W-1:0] duty_o
);
    localparam int unsigned PROD_W = 2 * LVL_W + 1;

    pwm_mode_e        mode;
    logic [VAL_W-1:0] glob_clamped;

    assign mode = pwm_mode_e'(glob_mode_i);

    always_comb begin
        if (32'(glob_i) > PERIOD) begin
            glob_clamped = VAL_W'(PERIOD);
        end else begin
            glob_clamped = VAL_W'(glob_i);
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic [PROD_W-1:0] steps;
        logic [PROD_W-1:0] prod;

        always_comb begin
            steps = PROD_W'(indiv_i[i*LVL_W +: LVL_W]) + PROD_W'(1);
            prod  = PROD_W'(master_i) * steps;
            if (mode == MODE_GLOBAL) begin
                duty_o[i*VAL_W +: VAL_W] = glob_clamped;
            end else begin
                duty_o[i*VAL_W +: VAL_W] = VAL_W'(prod);
            end
        end
    end

endmodule

// File: rtl/pwm2l_chan.sv
module pwm2l_chan #(
    parameter int unsigned VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [VAL_W-1:0] duty_i,
    input  logic [VAL_W-1:0] cnt_i,
    input  logic             pwm_en_i,
    input  logic             static_i,
    output logic [VAL_W-1:0] duty_o,
    output logic             pin_n_o
);
    typedef struct packed {
        logic [VAL_W-1:0] duty;
        logic             pin_n;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.duty = duty_i;
        end
        if (pwm_en_i) begin
            st_d.pin_n = !(cnt_i < st_q.duty);
        end else begin
            st_d.pin_n = static_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.duty  <= '0;
            st_q.pin_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o  = st_q.duty;
    assign pin_n_o = st_q.pin_n;

endmodule

// File: rtl/pwm2l_top.sv
module pwm2l_top
    import pwm2l_pkg::*;
#(
    parameter int unsigned N_OUT = 17,
    parameter int unsigned LVL_W = 4,
    parameter int unsigned GLB_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   osc_tick,
    output logic                   osc_run,
    input  logic                   glob_mode,
    input  logic [LVL_W-1:0]       master_lvl,
    input  logic [GLB_W-1:0]       glob_lvl,
    input  logic [N_OUT*LVL_W-1:0] indiv_lvl,
    input  logic [N_OUT-1:0]       pwm_en,
    input  logic [N_OUT-1:0]       static_lvl,
    output logic [N_OUT-1:0]       pin_n
);
    localparam int unsigned PERIOD = period_ticks(LVL_W);
    localparam int unsigned VAL_W  = $clog2(PERIOD + 1);

    logic                   load_w;
    logic [VAL_W-1:0]       cnt_w;
    logic [N_OUT*VAL_W-1:0] duty_new;
    logic [N_OUT*VAL_W-1:0] duty_all;

    pwm2l_period_cnt #(
        .PERIOD (PERIOD),
        .VAL_W  (VAL_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (osc_tick),
        .any_en_i (|pwm_en),
        .run_o    (osc_run),
        .cnt_o    (cnt_w),
        .load_o   (load_w)
    );

    pwm2l_duty_calc #(
        .N_OUT  (N_OUT),
        .LVL_W  (LVL_W),
        .GLB_W  (GLB_W),
        .VAL_W  (VAL_W),
        .PERIOD (PERIOD)
    ) u_calc (
        .glob_mode_i (glob_mode),
        .master_i    (master_lvl),
        .glob_i      (glob_lvl),
        .indiv_i     (indiv_lvl),
        .duty_o      (duty_new)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_ch
        pwm2l_chan #(
            .VAL_W (VAL_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_w),
            .duty_i   (duty_new[i*VAL_W +: VAL_W]),
            .cnt_i    (cnt_w),
            .pwm_en_i (pwm_en[i]),
            .static_i (static_lvl[i]),
            .duty_o   (duty_all[i*VAL_W +: VAL_W]),
            .pin_n_o  (pin_n[i])
        );
    end

endmodule

// File: rtl/pwm2l_chk.sv
module pwm2l_chk #(
    parameter int unsigned N_OUT  = 17,
    parameter int unsigned VAL_W  = 8,
    parameter int unsigned PERIOD = 240
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   osc_tick,
    input logic                   osc_run,
    input logic [N_OUT-1:0]       pwm_en,
    input logic [N_OUT-1:0]       static_lvl,
    input logic [N_OUT-1:0]       pin_n,
    input logic [VAL_W-1:0]       cnt_q,
    input logic [N_OUT*VAL_W-1:0] duty_all
);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < PERIOD);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_run && !osc_tick) |=> $stable(cnt_q));

    // R8
    run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (osc_run == $past(|pwm_en)));

    // R8
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> (cnt_q == '0));

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // R7
        duty_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (osc_run && !(osc_tick && 32'(cnt_q) == PERIOD - 1))
            |=> $stable(duty_all[i*VAL_W +: VAL_W]));

        // R6
        static_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_en[i] |=> (pin_n[i] == $past(static_lvl[i])));
    end

endmodule

bind pwm2l_top pwm2l_chk #(
    .N_OUT  (N_OUT),
    .VAL_W  (VAL_W),
    .PERIOD (PERIOD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .osc_run    (osc_run),
    .pwm_en     (pwm_en),
    .static_lvl (static_lvl),
    .pin_n      (pin_n),
    .cnt_q      (cnt_w),
    .duty_all   (duty_all)
);

// File: tb/test_pwm2l_top.sv
`timescale 1ns/1ps
module test_pwm2l_top;
    localparam int N   = 17;
    localparam int LW  = 4;
    localparam int GW  = 8;
    localparam int PER = 240;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          osc_run;
    logic          glob_mode = 1'b0;
    logic [LW-1:0] master_lvl = '0;
    logic [GW-1:0] glob_lvl = '0;
    logic [N*LW-1:0] indiv_lvl = '0;
    logic [N-1:0]  pwm_en = '0;
    logic [N-1:0]  static_lvl = '1;
    logic [N-1:0]  pin_n;

    int n_chk = 0;
    int n_bad = 0;
    int tick_div = 1;
    int lows [N];

    // bench-side configuration
    int cfg_m;
    int cfg_g;
    bit cfg_gm;
    int cfg_i [N];
    bit cfg_en [N];
    bit cfg_st [N];

    always #4 clk = ~clk;

    pwm2l_top i_pwm2l_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .osc_run    (osc_run),
        .glob_mode  (glob_mode),
        .master_lvl (master_lvl),
        .glob_lvl   (glob_lvl),
        .indiv_lvl  (indiv_lvl),
        .pwm_en     (pwm_en),
        .static_lvl (static_lvl),
        .pin_n      (pin_n)
    );

    // tick source: one pulse every tick_div cycles, driven at the falling edge
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (ph >= tick_div) ph = 0;
            osc_tick = (ph == 0);
            ph = ph + 1;
        end
    end

    function automatic int ref_duty(int m, int i, int g, bit gm);
        if (gm) return (g > PER) ? PER : g;
        return m * (i + 1);
    endfunction

    task automatic chk(string req, int idx, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s out %0d: got %0d exp %0d", req, idx, got, exp);
        end
    endtask

    task automatic apply();
        master_lvl = LW'(cfg_m);
        glob_lvl   = GW'(cfg_g);
        glob_mode  = cfg_gm;
        for (int i = 0; i < N; i++) begin
            indiv_lvl[i*LW +: LW] = LW'(cfg_i[i]);
            pwm_en[i]     = cfg_en[i];
            static_lvl[i] = cfg_st[i];
        end
    endtask

    task automatic window();
        repeat (2 * PER * tick_div + 4) @(negedge clk);
        for (int i = 0; i < N; i++) lows[i] = 0;
        repeat (PER * tick_div) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (pin_n[i] === 1'b0) lows[i]++;
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < N; i++) begin
            int exp;
            if (cfg_en[i]) exp = ref_duty(cfg_m, cfg_i[i], cfg_g, cfg_gm) * tick_div;
            else exp = cfg_st[i] ? 0 : PER * tick_div;
            chk(req, i, lows[i], exp);
        end
    endtask

    task automatic base_cfg();
        cfg_m = 15; cfg_g = 0; cfg_gm = 0;
        for (int i = 0; i < N; i++) begin
            cfg_i[i] = 15; cfg_en[i] = 1; cfg_st[i] = 1;
        end
    endtask

    task automatic fall_gap(int idx, output int gap);
        bit prev;
        int c;
        prev = pin_n[idx];
        forever begin
            @(negedge clk);
            if (prev && !pin_n[idx]) break;
            prev = pin_n[idx];
        end
        c = 0;
        prev = pin_n[idx];
        forever begin
            @(negedge clk);
            c++;
            if (prev && !pin_n[idx]) break;
            prev = pin_n[idx];
        end
        gap = c;
    endtask

    initial begin
        int unsigned sd;
        int gap;
        sd = $urandom(32'd20240611);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", 0, int'(pin_n == '1), 1);
        chk("R1", 0, int'(osc_run), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, int'(pin_n == '1), 1);
        chk("R1", 0, int'(osc_run), 0);

        // R8: oscillator request follows the enables one clock later
        base_cfg();
        for (int i = 0; i < N; i++) cfg_en[i] = 0;
        cfg_en[4] = 1;
        apply();
        @(negedge clk);
        chk("R8", 4, int'(osc_run), 1);

        // R4: full master and full individual give a continuous low
        base_cfg();
        cfg_i[1] = 0; cfg_i[2] = 7;
        apply();
        window();
        check_all("R4");

        // R3: master zero turns everything off regardless of individual level
        base_cfg();
        cfg_m = 0;
        apply();
        window();
        check_all("R3");

        // R5: global clamp corners 0, 240, 241, 255 and individual levels ignored
        foreach (cfg_i[k]) cfg_i[k] = k % 16;
        for (int k = 0; k < 4; k++) begin
            base_cfg();
            cfg_gm = 1; cfg_m = 3;
            cfg_g = (k == 0) ? 0 : (k == 1) ? 240 : (k == 2) ? 241 : 255;
            apply();
            window();
            check_all("R5");
        end

        // R2: period length at two tick rates, and on-time scaled by the tick rate
        base_cfg();
        cfg_m = 8; cfg_i[0] = 7;
        apply();
        tick_div = 1;
        window();
        fall_gap(0, gap);
        chk("R2", 0, gap, PER);
        tick_div = 3;
        cfg_m = 10; cfg_i[0] = 5;
        apply();
        window();
        check_all("R2");
        fall_gap(0, gap);
        chk("R2", 0, gap, PER * 3);
        tick_div = 1;

        // R7: mid-period change applies only from the next period
        base_cfg();
        cfg_i[0] = 3; cfg_i[1] = 7;
        apply();
        repeat (2 * PER + 4) @(negedge clk);
        begin
            bit prev;
            int c0;
            prev = pin_n[1];
            forever begin
                @(negedge clk);
                if (prev && !pin_n[1]) break;
                prev = pin_n[1];
            end
            c0 = 0;
            for (int k = 0; k < PER; k++) begin
                if (k > 0) @(negedge clk);
                if (!pin_n[0]) c0++;
                if (k == 100) begin
                    cfg_i[0] = 11;
                    apply();
                end
            end
            chk("R7", 0, c0, 60);
            c0 = 0;
            for (int k = 0; k < PER; k++) begin
                @(negedge clk);
                if (!pin_n[0]) c0++;
            end
            chk("R7", 0, c0, 180);
        end

        // R6: a static output follows its level one clock later while others pulse
        base_cfg();
        cfg_en[5] = 0; cfg_m = 9;
        apply();
        for (int k = 0; k < 24; k++) begin
            bit v;
            v = 1'($urandom_range(1, 0));
            static_lvl[5] = v;
            @(negedge clk);
            chk("R6", 5, int'(pin_n[5]), int'(v));
        end

        // R8: all PWM off stops the oscillator request; pins show static levels
        base_cfg();
        for (int i = 0; i < N; i++) begin
            cfg_en[i] = 0; cfg_st[i] = (i % 3 != 0);
        end
        apply();
        repeat (2) @(negedge clk);
        chk("R8", 0, int'(osc_run), 0);
        window();
        check_all("R6");

        // R3/R5: random configurations at two tick rates
        for (int it = 0; it < 22; it++) begin
            int any;
            cfg_m  = $urandom_range(15, 0);
            cfg_gm = ($urandom_range(3, 0) == 0);
            cfg_g  = $urandom_range(255, 0);
            any = 0;
            for (int i = 0; i < N; i++) begin
                cfg_i[i]  = $urandom_range(15, 0);
                cfg_en[i] = ($urandom_range(3, 0) != 0);
                cfg_st[i] = 1'($urandom_range(1, 0));
                if (cfg_en[i]) any = 1;
            end
            if (any == 0) cfg_en[$urandom_range(N - 1, 0)] = 1;
            tick_div = (it % 4 == 3) ? 2 : 1;
            apply();
            window();
            check_all(cfg_gm ? "R5" : "R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule